// File: doc/BRIEF.md
# ModRM/SIB operand-tail collector

This block collects the bytes that follow an already-decoded opcode of a variable-length instruction: the addressing byte (ModRM), an optional scale/index/base byte (SIB), a displacement and an immediate. It takes one byte per accepted cycle from a valid/ready stream. From the fields already gathered it works out how many more bytes belong to the instruction. When the last byte has been taken it pulses `done_o`, with the assembled fields on its outputs.

A front end pulses `start_i` while the collector is idle, with the instruction context on the same cycle: address size, operand size, whether the opcode comes from the one-byte map, the opcode itself and the immediate size taken from the opcode tables. The collector latches this context and raises `byte_ready_o` on the next cycle. The outputs hold their values until the next start.

Top module: `modrm_tail_collector`

## Requirements
- R1: After reset, `byte_ready_o` and `done_o` are low, and `modrm_o`, `sib_o`, `sib_present_o`, `disp_o` and `imm_o` are all zero.
- R2: A `start_i` pulse while idle latches the context inputs (`addr_size_i`: 0 means 16-bit, 1 means 32-bit, 2 means 64-bit; `op_size_i` and `imm_size_i` in bytes). `byte_ready_o` is high from the next cycle until the final byte is accepted. The ModRM byte is always consumed, even when nothing follows it. Later changes to the context inputs have no effect. Bytes offered while idle are ignored.
- R3: With 16-bit addressing the displacement is 2 bytes when mod=2, or when mod=0 and rm=6. It is 1 byte when mod=1 and 0 bytes otherwise. mod is ModRM bits 7:6 and rm is bits 2:0.
- R4: With 32- or 64-bit addressing the displacement is 4 bytes when mod=2, or when mod=0 and rm=5. It is 1 byte when mod=1 and 0 bytes otherwise.
- R5: A SIB byte is taken only when rm=4, mod is not 3 and the addressing is not 16-bit. `sib_present_o` reports whether it was taken.
- R6: When mod=0 and the SIB base field (bits 2:0) is 5, the displacement is 4 bytes.
- R7: For opcode 0xF6 in the one-byte map with ModRM bits 5:4 equal to 00, the immediate is 1 byte. For 0xF7 under the same condition, the immediate is the operand size capped at 4 bytes. In every other case `imm_size_i` applies.
- R8: `disp_o` is the displacement sign-extended to 64 bits from its 1-, 2- or 4-byte size.
- R9: A 1- or 4-byte immediate is sign-extended to 64 bits. A 2- or 8-byte immediate is zero-extended.
- R10: Bytes arrive in a fixed order: ModRM, SIB, displacement, immediate. Multi-byte fields are little-endian. `done_o` is high for exactly one cycle, the cycle after the last byte is accepted. `byte_ready_o` is low during that cycle.
- R11: A cycle with `byte_valid_i` low while `byte_ready_o` is high changes no state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin collection; taken only while idle |
| addr_size_i | input | 2 | 0 = 16-bit, 1 = 32-bit, 2 = 64-bit addressing |
| op_size_i | input | 4 | Operand size in bytes (2, 4, 8) |
| one_byte_map_i | input | 1 | Opcode belongs to the one-byte map |
| opcode_i | input | 8 | Opcode byte |
| imm_size_i | input | 4 | Immediate size from the tables (0, 1, 2, 4, 8) |
| byte_i | input | 8 | Stream byte |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_ready_o | output | 1 | Collector accepts a byte |
| done_o | output | 1 | One-cycle completion pulse |
| modrm_o | output | 8 | Captured ModRM |
| sib_o | output | 8 | Captured SIB |
| sib_present_o | output | 1 | A SIB byte was taken |
| disp_o | output | 64 | Sign-extended displacement |
| imm_o | output | 64 | Extended immediate |

## Verification
The bench covers the following corner cases:
- **16-bit rm=4.** This encoding must not fetch a SIB byte. A design that checks only rm would swallow a displacement byte as SIB and finish one byte late.
- **mod=0 with SIB base 5.** This must add a 4-byte displacement. With mod=1 the same base must not; a wrong design loses or invents bytes there.
- **Negative values.** Negative 1-, 2- and 4-byte displacements show a missing sign extension. Immediates with the top bit set show the wrong choice between sign and zero extension.
- **The F6/F7 group.** Tested with reg 0, 1 and 2, across operand sizes and outside the one-byte map. A wrong design shows a missing or over-long immediate.
- **Stalls and idle bytes.** Stall cycles and bytes offered while idle show any design that advances without a handshake.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_MODRM, ST_SIB, ST_DISP, ST_IMM, ST_DONE
  } mtc_state_e;

  localparam logic [1:0] ASZ_16 = 2'd0;

  function automatic logic [63:0] sext_by_size(input logic [63:0] raw,
                                               input logic [3:0]  nbytes);
    case (nbytes)
      4'd1:    return {{56{raw[7]}},  raw[7:0]};
      4'd2:    return {{48{raw[15]}}, raw[15:0]};
      4'd4:    return {{32{raw[31]}}, raw[31:0]};
      default: return raw;
    endcase
  endfunction
endpackage

// File: rtl/mtc_disp_sizer.sv
module mtc_disp_sizer #(
  parameter int SW = 4
) (
  input  logic [7:0]    modrm_i,
  input  logic          addr16_i,
  output logic [SW-1:0] size_o
);
  logic [1:0] md;
  logic [2:0] rm;
  assign md = modrm_i[7:6];
  assign rm = modrm_i[2:0];

  always_comb begin
    size_o = '0;
    if (addr16_i) begin
      if ((md == 2'd0 && rm == 3'd6) || md == 2'd2) size_o = SW'(2);
      else if (md == 2'd1)                          size_o = SW'(1);
    end else begin
      if ((md == 2'd0 && rm == 3'd5) || md == 2'd2) size_o = SW'(4);
      else if (md == 2'd1)                          size_o = SW'(1);
    end
  end
endmodule

// File: rtl/mtc_imm_adjust.sv
module mtc_imm_adjust #(
  parameter int SW = 4
) (
  input  logic          one_byte_map_i,
  input  logic [7:0]    opcode_i,
  input  logic [7:0]    modrm_i,
  input  logic [SW-1:0] op_size_i,
  input  logic [SW-1:0] imm_size_i,
  output logic [SW-1:0] imm_size_o
);
  logic grp_test;
  // reg field values 0 and 1 of the group select the test form
  assign grp_test = one_byte_map_i && (modrm_i[5:4] == 2'b00);

  always_comb begin
    imm_size_o = imm_size_i;
    if (grp_test && opcode_i == 8'hF6) imm_size_o = SW'(1);
    else if (grp_test && opcode_i == 8'hF7)
      imm_size_o = (op_size_i == SW'(8)) ? SW'(4) : op_size_i;
  end
endmodule

// File: rtl/mtc_field_acc.sv
module mtc_field_acc #(
  parameter int DW = 64,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [7:0]    byte_i,
  input  logic [SW-1:0] size_i,
  output logic [DW-1:0] value_o,
  output logic          last_o
);
  localparam int NB = DW / 8;

  logic [SW-1:0] cnt_q;

  assign last_o = (cnt_q == size_i - SW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= last_o ? '0 : cnt_q + SW'(1);
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           lane_q <= '0;
      else if (clr_i)                        lane_q <= '0;
      else if (en_i && cnt_q == SW'(b))      lane_q <= byte_i;
    end
    assign value_o[b*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/modrm_tail_collector.sv
module modrm_tail_collector #(
  parameter int DW = 64,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    addr_size_i,
  input  logic [3:0]    op_size_i,
  input  logic          one_byte_map_i,
  input  logic [7:0]    opcode_i,
  input  logic [3:0]    imm_size_i,
  input  logic [7:0]    byte_i,
  input  logic          byte_valid_i,
  output logic          byte_ready_o,
  output logic          done_o,
  output logic [7:0]    modrm_o,
  output logic [7:0]    sib_o,
  output logic          sib_present_o,
  output logic [63:0]   disp_o,
  output logic [63:0]   imm_o
);
  import mtc_pkg::*;

  mtc_state_e st_q;
  logic          addr16_q, map_q;
  logic [7:0]    opc_q, modrm_q, sib_q;
  logic [SW-1:0] opsz_q, immsz_q, dsz_q;
  logic          sibp_q;

  logic          accept, load;
  logic [SW-1:0] dsz_mrm, immsz_mrm, dsz_sib;
  logic          need_sib;
  logic [DW-1:0] disp_raw, imm_raw;
  logic          disp_last, imm_last;

  assign byte_ready_o = (st_q == ST_MODRM) || (st_q == ST_SIB) ||
                        (st_q == ST_DISP)  || (st_q == ST_IMM);
  assign accept = byte_ready_o && byte_valid_i;
  assign load   = (st_q == ST_IDLE) && start_i;
  assign done_o = (st_q == ST_DONE);

  mtc_disp_sizer #(.SW(SW)) u_sizer (
    .modrm_i (byte_i),
    .addr16_i(addr16_q),
    .size_o  (dsz_mrm)
  );

  mtc_imm_adjust #(.SW(SW)) u_immadj (
    .one_byte_map_i(map_q),
    .opcode_i      (opc_q),
    .modrm_i       (byte_i),
    .op_size_i     (opsz_q),
    .imm_size_i    (immsz_q),
    .imm_size_o    (immsz_mrm)
  );

  assign need_sib = (byte_i[2:0] == 3'd4) && (byte_i[7:6] != 2'd3) && !addr16_q;
  assign dsz_sib  = (modrm_q[7:6] == 2'd0 && byte_i[2:0] == 3'd5) ? SW'(4) : dsz_q;

  mtc_field_acc #(.DW(DW), .SW(SW)) u_disp_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .en_i   (accept && st_q == ST_DISP),
    .byte_i (byte_i),
    .size_i (dsz_q),
    .value_o(disp_raw),
    .last_o (disp_last)
  );

  mtc_field_acc #(.DW(DW), .SW(SW)) u_imm_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load),
    .en_i   (accept && st_q == ST_IMM),
    .byte_i (byte_i),
    .size_i (immsz_q),
    .value_o(imm_raw),
    .last_o (imm_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr16_q <= 1'b0;
      map_q    <= 1'b0;
      opc_q    <= '0;
      opsz_q   <= '0;
      immsz_q  <= '0;
      dsz_q    <= '0;
      modrm_q  <= '0;
      sib_q    <= '0;
      sibp_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          addr16_q <= (addr_size_i == ASZ_16);
          map_q    <= one_byte_map_i;
          opc_q    <= opcode_i;
          opsz_q   <= SW'(op_size_i);
          immsz_q  <= SW'(imm_size_i);
          dsz_q    <= '0;
          modrm_q  <= '0;
          sib_q    <= '0;
          sibp_q   <= 1'b0;
          st_q     <= ST_MODRM;
        end
        ST_MODRM: if (accept) begin
          modrm_q <= byte_i;
          dsz_q   <= dsz_mrm;
          immsz_q <= immsz_mrm;
          sibp_q  <= need_sib;
          if (need_sib)                  st_q <= ST_SIB;
          else if (dsz_mrm != '0)        st_q <= ST_DISP;
          else if (immsz_mrm != '0)      st_q <= ST_IMM;
          else                           st_q <= ST_DONE;
        end
        ST_SIB: if (accept) begin
          sib_q <= byte_i;
          dsz_q <= dsz_sib;
          if (dsz_sib != '0)             st_q <= ST_DISP;
          else if (immsz_q != '0)        st_q <= ST_IMM;
          else                           st_q <= ST_DONE;
        end
        ST_DISP: if (accept && disp_last)
          st_q <= (immsz_q != '0) ? ST_IMM : ST_DONE;
        ST_IMM: if (accept && imm_last)
          st_q <= ST_DONE;
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign modrm_o       = modrm_q;
  assign sib_o         = sib_q;
  assign sib_present_o = sibp_q;
  assign disp_o        = sext_by_size(disp_raw, 4'(dsz_q));
  assign imm_o         = (immsz_q == SW'(1) || immsz_q == SW'(4))
                         ? sext_by_size(imm_raw, 4'(immsz_q)) : imm_raw;
endmodule

// File: rtl/modrm_tail_collector_chk.sv
module modrm_tail_collector_chk (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               byte_valid_i,
  input logic               byte_ready_o,
  input logic               done_o,
  input logic [7:0]         modrm_o,
  input logic [7:0]         sib_o,
  input logic               sib_present_o,
  input logic [63:0]        disp_o,
  input logic [63:0]        imm_o,
  input mtc_pkg::mtc_state_e st_q
);
  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_no_ready_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !byte_ready_o);

  a_r2_start_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == mtc_pkg::ST_IDLE && start_i) |=> byte_ready_o);

  a_r11_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_ready_o && !byte_valid_i) |=>
      (byte_ready_o && $stable(modrm_o) && $stable(sib_o) &&
       $stable(disp_o) && $stable(imm_o)));

  a_r5_sib_rm4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sib_present_o) |-> (modrm_o[2:0] == 3'd4 && modrm_o[7:6] != 2'd3));

  a_r8_disp_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (disp_o[63:32] == {32{disp_o[31]}}));
endmodule

bind modrm_tail_collector modrm_tail_collector_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .byte_valid_i (byte_valid_i),
  .byte_ready_o (byte_ready_o),
  .done_o       (done_o),
  .modrm_o      (modrm_o),
  .sib_o        (sib_o),
  .sib_present_o(sib_present_o),
  .disp_o       (disp_o),
  .imm_o        (imm_o),
  .st_q         (st_q)
);

// File: tb/modrm_tail_collector_bench.sv
module modrm_tail_collector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  addr_size = '0;
  logic [3:0]  op_size = '0;
  logic        map1 = 1'b0;
  logic [7:0]  opcode = '0;
  logic [3:0]  imm_size = '0;
  logic [7:0]  bdat = '0;
  logic        bvalid = 1'b0;
  logic        bready, done;
  logic [7:0]  modrm, sib;
  logic        sibp;
  logic [63:0] disp, imm;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  modrm_tail_collector u_modrm_tail_collector (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_size_i(addr_size),
    .op_size_i(op_size), .one_byte_map_i(map1), .opcode_i(opcode),
    .imm_size_i(imm_size), .byte_i(bdat), .byte_valid_i(bvalid),
    .byte_ready_o(bready), .done_o(done), .modrm_o(modrm), .sib_o(sib),
    .sib_present_o(sibp), .disp_o(disp), .imm_o(imm)
  );

  typedef struct {
    logic [7:0]  modrm;
    logic        sibp;
    logic [7:0]  sib;
    logic [63:0] disp;
    logic [63:0] imm;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [63:0] ext(input logic [63:0] raw, input int n, input bit sgn);
    logic [63:0] r;
    r = raw;
    if (sgn) begin
      if (n == 1) r = {{56{raw[7]}}, raw[7:0]};
      if (n == 2) r = {{48{raw[15]}}, raw[15:0]};
      if (n == 4) r = {{32{raw[31]}}, raw[31:0]};
    end
    return r;
  endfunction

  // expected fields and byte count, built from the requirement text
  task automatic model(input logic [1:0] asz, input logic [3:0] osz, input bit m1,
                       input logic [7:0] opc, input logic [3:0] isz_in,
                       input logic [127:0] bv, output exp_t e, output int nb);
    int idx, dsz, isz;
    logic [7:0] m;
    logic [63:0] raw;
    bit a16;
    m = bv[7:0]; idx = 1; a16 = (asz == 2'd0);
    e.modrm = m; e.sib = '0; e.sibp = 1'b0;
    if (a16) dsz = ((m[7:6] == 0 && m[2:0] == 6) || m[7:6] == 2) ? 2 : (m[7:6] == 1) ? 1 : 0;
    else     dsz = ((m[7:6] == 0 && m[2:0] == 5) || m[7:6] == 2) ? 4 : (m[7:6] == 1) ? 1 : 0;
    isz = int'(isz_in);
    if (m1 && m[5:4] == 2'b00 && opc == 8'hF6) isz = 1;
    if (m1 && m[5:4] == 2'b00 && opc == 8'hF7) isz = (osz == 8) ? 4 : int'(osz);
    if (m[2:0] == 4 && m[7:6] != 3 && !a16) begin
      e.sibp = 1'b1; e.sib = bv[idx*8 +: 8]; idx++;
      if (m[7:6] == 0 && e.sib[2:0] == 5) dsz = 4;
    end
    raw = '0;
    for (int k = 0; k < dsz; k++) begin raw[k*8 +: 8] = bv[idx*8 +: 8]; idx++; end
    e.disp = ext(raw, dsz, 1'b1);
    raw = '0;
    for (int k = 0; k < isz; k++) begin raw[k*8 +: 8] = bv[idx*8 +: 8]; idx++; end
    e.imm = ext(raw, isz, (isz == 1 || isz == 4));
    nb = idx;
  endtask

  task automatic run_case(input string tag, input logic [1:0] asz, input logic [3:0] osz,
                          input bit m1, input logic [7:0] opc, input logic [3:0] isz,
                          input logic [127:0] bv, input int gap_at);
    exp_t e;
    int nb;
    model(asz, osz, m1, opc, isz, bv, e, nb);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b1; addr_size = asz; op_size = osz; map1 = m1; opcode = opc; imm_size = isz;
    @(negedge clk);
    start = 1'b0;
    // scramble context: latched values must be used (R2)
    addr_size = ~asz; opcode = ~opc; imm_size = 4'd8; map1 = ~m1; op_size = 4'd8;
    for (int k = 0; k < nb; k++) begin
      if (k == gap_at) begin
        bvalid = 1'b0; bdat = 8'hEE;
        @(negedge clk);
        chk(bready == 1'b1, "R11", "ready during stall", 64'(bready), 64'd1);
      end
      chk(bready == 1'b1, "R2", "ready before byte", 64'(bready), 64'd1);
      bvalid = 1'b1; bdat = bv[k*8 +: 8];
      @(negedge clk);
    end
    bvalid = 1'b0;
    chk(bready == 1'b0, "R10", "ready after last byte", 64'(bready), 64'd0);
    chk(done == 1'b1, "R10", "done after last byte", 64'(done), 64'd1);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single cycle", 64'(done), 64'd0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(modrm == e.modrm, t, "modrm", 64'(modrm), 64'(e.modrm));
        chk(sibp == e.sibp, t, "sib_present", 64'(sibp), 64'(e.sibp));
        if (e.sibp) chk(sib == e.sib, t, "sib", 64'(sib), 64'(e.sib));
        chk(disp == e.disp, t, "disp", disp, e.disp);
        chk(imm == e.imm, t, "imm", imm, e.imm);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bready == 1'b0 && done == 1'b0, "R1", "ready/done after reset", {62'd0, bready, done}, 64'd0);
    chk(modrm == 0 && sib == 0 && !sibp && disp == 0 && imm == 0, "R1", "fields after reset",
        disp | imm | 64'(modrm), 64'd0);
    // R2: bytes offered while idle are ignored
    bvalid = 1'b1; bdat = 8'h55;
    repeat (3) begin
      @(negedge clk);
      chk(bready == 1'b0, "R2", "idle ignores bytes", 64'(bready), 64'd0);
    end
    bvalid = 1'b0;

    run_case("R3_mod0_rm6",   2'd0, 4'd2, 1'b0, 8'h8B, 4'd0, 128'h92_34_06, -1);
    run_case("R3_mod1_rm4",   2'd0, 4'd2, 1'b0, 8'h81, 4'd2, 128'hAB_CD_80_44, 1);
    run_case("R3_mod3_only",  2'd0, 4'd2, 1'b0, 8'h01, 4'd0, 128'hC0, -1);
    run_case("R4_mod2",       2'd1, 4'd4, 1'b0, 8'h81, 4'd4, 128'hFF_FF_FF_FF_12_34_56_78_81, 3);
    run_case("R8_mod0_rm5",   2'd1, 4'd4, 1'b0, 8'h8B, 4'd0, 128'h80_00_00_00_05, -1);
    run_case("R6_sib_base5",  2'd2, 4'd8, 1'b0, 8'h8B, 4'd0, 128'h04_03_02_01_25_04, 2);
    run_case("R6_mod1_base5", 2'd2, 4'd8, 1'b0, 8'h8B, 4'd0, 128'h7F_25_44, -1);
    run_case("R5_mod3_rm4",   2'd1, 4'd4, 1'b0, 8'h83, 4'd1, 128'h90_C4, -1);
    run_case("R5_sib_nodisp", 2'd1, 4'd4, 1'b0, 8'h8B, 4'd0, 128'h03_04, -1);
    run_case("R7_f6_reg0",    2'd1, 4'd4, 1'b1, 8'hF6, 4'd0, 128'h85_C0, -1);
    run_case("R7_f7_os8",     2'd2, 4'd8, 1'b1, 8'hF7, 4'd0, 128'h80_11_22_33_C8, -1);
    run_case("R7_f7_reg2",    2'd1, 4'd2, 1'b1, 8'hF7, 4'd0, 128'hD0, -1);
    run_case("R9_f7_os2",     2'd1, 4'd2, 1'b1, 8'hF7, 4'd0, 128'h80_01_C0, -1);
    run_case("R7_f6_notmap",  2'd1, 4'd4, 1'b0, 8'hF6, 4'd0, 128'hC0, -1);
    run_case("R9_imm8_zext",  2'd2, 4'd8, 1'b0, 8'hB8, 4'd8, 128'hF0_DE_BC_9A_78_56_34_12_C1, 5);
    run_case("R8_disp8_pos",  2'd2, 4'd8, 1'b0, 8'h8B, 4'd0, 128'h7F_45, -1);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "all results seen", 64'(exp_q.size()), 64'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule